// File: doc/BRIEF.md
# Synchronous Multi-Ratio Clock Divider

This block turns one input clock into two phase-aligned divided clocks. The fine output runs at either the input rate or half of it. The coarse output runs at one of four ratios: 2, 3, 4 or 6. Two select inputs choose the ratio pair, and the choice can change while the block runs. A new ratio takes effect only when the shared phase counter wraps, so the block never emits a pulse of the wrong length.

All divider state advances from one internal run gate. An active-low enable is captured on the falling edge of the input clock, so the gate can only open or close while the clock is low, and no shortened pulse can appear on any output. A master reset clears every divider at once and forces both outputs low. The release of that reset is synchronized to the input clock. Several instances released from the same reset therefore start on the same input edge and stay in lockstep.

Top module: `sync_ratio_divider`

## Requirements
- R1: With `fast_sel` low, `clk_fine` divides by 2 (high one input cycle, low one). `clk_coarse` divides by 4 when `alt_sel` is low and by 6 when it is high, with 50% duty (high 2 / low 2, or high 3 / low 3 input cycles).
- R2: With `fast_sel` high, `clk_fine` follows the input clock level while the gate is open. `clk_coarse` divides by 2 (high 1 / low 1) when `alt_sel` is low, and by 3 (high 2 / low 1 input cycles) when `alt_sel` is high.
- R3: While `run_n` is high, neither output changes state. In the pass-through ratio, `clk_fine` stays low for the whole hold.
- R4: `run_n` is captured on the falling edge of `clk_in`. The gate therefore opens and closes only while `clk_in` is low, and no output pulse is shorter than one input half-period.
- R5: Every output transition happens on a rising edge of `clk_in`, or on its falling edge for a pass-through low half. Whenever `clk_coarse` rises, `clk_fine` rises with it on the same rising edge.
- R6: While `mreset` is high, both outputs are low regardless of the clock, and all dividers are cleared.
- R7: After `mreset` falls, the dividers stay cleared for two rising edges of `clk_in`. With `run_n` low, the third rising edge after the release drives both outputs high together.
- R8: `fast_sel` and `alt_sel` are sampled on the rising edge of `clk_in`. They take effect only on an edge where the phase counter wraps: the counter runs from 0 to the active period minus 1, and the first edge after reset also counts as a wrap. Between wraps, a change on either select has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; all ratios derive from it |
| mreset | input | 1 | Asynchronous master reset, active high |
| run_n | input | 1 | Active-low enable, captured on the falling edge |
| fast_sel | input | 1 | Ratio-pair select: high gives 1 and 2/3, low gives 2 and 4/6 |
| alt_sel | input | 1 | Picks the larger coarse ratio within the pair |
| clk_fine | output | 1 | Divide-by-1 or divide-by-2 output |
| clk_coarse | output | 1 | Divide-by-2/3 or divide-by-4/6 output |

## Verification
Some properties are checked by assertions on every cycle:
- the phase counter stays below the active period;
- the ratio register changes only on an enabled wrap edge;
- state holds while the gate is closed;
- the gate stays shut while the dividers are in reset;
- a rising edge on the coarse output always coincides with the fine output going high;
- both outputs are low whenever reset is high.

The exact high and low lengths of each ratio need the bench's scenarios, which compare against a behavioural model at the middle of every input half-period. The same holds for the three-edge restart latency after reset, the pass-through output staying low through a hold, and selects changed in mid-period waiting for the wrap.

// File: rtl/sync_ratio_divider_pkg.sv
package sync_ratio_divider_pkg;

    // Selected ratio pair: fast picks the 1 and 2/3 set, alt picks the larger coarse ratio
    typedef struct packed {
        logic fast;
        logic alt;
    } ratio_sel_t;

endpackage

// File: rtl/srd_gate.sv
// Reset release synchronizer and falling-edge run gate
module srd_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_n,
    output logic run_o,
    output logic div_rst_o
);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   run_d, run_q;

    always_comb begin
        sync_d = sync_q << 1;
        // the gate may only open once the dividers are out of reset
        run_d  = !run_n && !sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sync_q <= '1;
        else     sync_q <= sync_d;
    end

    // Captured while the clock is low, so the gate only moves in the low half
    always_ff @(negedge clk or posedge rst) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= run_d;
    end

    assign run_o     = run_q;
    assign div_rst_o = sync_q[SYNC_STAGES-1];

    assert_gate_shut_in_reset_R7: assert property (
        @(posedge clk) disable iff (rst) div_rst_o |-> !run_o
    );

endmodule

// File: rtl/srd_core.sv
// Shared phase counter; both divided outputs are decoded from it
module srd_core
    import sync_ratio_divider_pkg::*;
#(
    parameter int SLOW_LO = 4,
    parameter int SLOW_HI = 6,
    parameter int FAST_LO = 2,
    parameter int FAST_HI = 3
) (
    input  logic       clk,
    input  logic       div_rst,
    input  logic       run,
    input  ratio_sel_t sel,
    output ratio_sel_t mode_o,
    output logic       half_o,
    output logic       coarse_o
);

    localparam int MAX_AB = (SLOW_LO > SLOW_HI) ? SLOW_LO : SLOW_HI;
    localparam int MAX_CD = (FAST_LO > FAST_HI) ? FAST_LO : FAST_HI;
    localparam int MAXR   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int PH_W   = (MAXR > 2) ? $clog2(MAXR) : 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            idle;
        ratio_sel_t      mode;
        logic            half;
        logic            coarse;
    } core_st_t;

    localparam core_st_t RST_ST = '{ph: '0, idle: 1'b1, mode: '0, half: 1'b0, coarse: 1'b0};

    function automatic int period_of(input ratio_sel_t m);
        case ({m.fast, m.alt})
            2'b00:   return SLOW_LO;
            2'b01:   return SLOW_HI;
            2'b10:   return FAST_LO;
            default: return FAST_HI;
        endcase
    endfunction

    core_st_t st_d, st_q;
    logic     term;

    always_comb begin
        term = st_q.idle || (st_q.ph == PH_W'(period_of(st_q.mode) - 1));
        st_d = st_q;
        if (run) begin
            if (term) begin
                st_d.mode = sel;
                st_d.ph   = '0;
                st_d.idle = 1'b0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
            st_d.coarse = int'(st_d.ph) < ((period_of(st_d.mode) + 1) / 2);
            st_d.half   = !st_d.ph[0];
        end
    end

    always_ff @(posedge clk or posedge div_rst) begin
        if (div_rst) st_q <= RST_ST;
        else         st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign half_o   = st_q.half;
    assign coarse_o = st_q.coarse;

    assert_phase_in_range_R1: assert property (
        @(posedge clk) disable iff (div_rst) int'(st_q.ph) < period_of(st_q.mode)
    );

    assert_hold_when_gated_R3: assert property (
        @(posedge clk) disable iff (div_rst) !run |=> $stable(st_q)
    );

    assert_ratio_at_wrap_R8: assert property (
        @(posedge clk) disable iff (div_rst) !$stable(st_q.mode) |-> $past(term && run)
    );

    assert_edges_aligned_R5: assert property (
        @(posedge clk) disable iff (div_rst) $rose(st_q.coarse) |-> st_q.half
    );

endmodule

// File: rtl/sync_ratio_divider.sv
module sync_ratio_divider
    import sync_ratio_divider_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOW_LO     = 4,
    parameter int SLOW_HI     = 6,
    parameter int FAST_LO     = 2,
    parameter int FAST_HI     = 3
) (
    input  logic clk_in,
    input  logic mreset,
    input  logic run_n,
    input  logic fast_sel,
    input  logic alt_sel,
    output logic clk_fine,
    output logic clk_coarse
);

    logic       run, div_rst, half;
    ratio_sel_t sel, mode;

    assign sel = '{fast: fast_sel, alt: alt_sel};

    srd_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk       (clk_in),
        .rst       (mreset),
        .run_n     (run_n),
        .run_o     (run),
        .div_rst_o (div_rst)
    );

    srd_core #(
        .SLOW_LO (SLOW_LO),
        .SLOW_HI (SLOW_HI),
        .FAST_LO (FAST_LO),
        .FAST_HI (FAST_HI)
    ) u_core (
        .clk      (clk_in),
        .div_rst  (div_rst),
        .run      (run),
        .sel      (sel),
        .mode_o   (mode),
        .half_o   (half),
        .coarse_o (clk_coarse)
    );

    // Pass-through ratio: the gated clock itself; the gate only moves while clk_in is low
    assign clk_fine = mode.fast ? (clk_in & run) : half;

    always @(negedge clk_in) begin
        if (mreset) begin
            assert_reset_low_R6: assert (!clk_fine && !clk_coarse);
        end
    end

endmodule

// File: tb/sync_ratio_divider_test.sv
`timescale 1ns/1ps
module sync_ratio_divider_test;

    logic clk = 1'b0;
    logic rst = 1'b1, run_n = 1'b1, fsel = 1'b0, asel = 1'b0;
    logic q_fine, q_coarse;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R6";
    bit    done = 1'b0;

    // behavioural reference state
    int ph_m = -1, rel = 0;
    bit run_m = 1'b0, mf = 1'b0, ma = 1'b0;

    sync_ratio_divider uut (
        .clk_in(clk), .mreset(rst), .run_n(run_n), .fast_sel(fsel),
        .alt_sel(asel), .clk_fine(q_fine), .clk_coarse(q_coarse)
    );

    always #5 clk = ~clk;

    function automatic int per(bit f, bit a);
        return f ? (a ? 3 : 2) : (a ? 6 : 4);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            rel = 0; ph_m = -1; run_m = 0; mf = 0; ma = 0;
        end else begin
            if (run_m) begin
                if (ph_m < 0 || ph_m == per(mf, ma) - 1) begin
                    mf = fsel; ma = asel; ph_m = 0;
                end else ph_m++;
            end
            if (rel < 1000) rel++;
        end
    end

    always @(negedge clk) run_m = !rst && rel >= 2 && !run_n;

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic ef, ec;
        if (rst) begin
            ef = 0; ec = 0;
        end else begin
            ec = ph_m >= 0 && ph_m < (per(mf, ma) + 1) / 2;
            ef = mf ? (clk & run_m) : (ph_m >= 0 && ph_m % 2 == 0);
        end
        check(cur_req, q_fine, ef, "clk_fine");
        check(cur_req, q_coarse, ec, "clk_coarse");
    endtask

    always @(posedge clk) begin #3; if (!done) compare_model(); end
    always @(negedge clk) begin #3; if (!done) compare_model(); end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic held;
        // R6: reset state
        cycles(3);
        check("R6", q_fine, 1'b0, "reset clk_fine");
        check("R6", q_coarse, 1'b0, "reset clk_coarse");

        // R7: release with gate requested open; first edge is the third one
        cur_req = "R7";
        rst = 0; run_n = 0;
        @(posedge clk); #3; check("R7", q_coarse, 1'b0, "edge1");
        @(posedge clk); #3; check("R7", q_coarse, 1'b0, "edge2");
        @(posedge clk); #3; check("R7", q_coarse, 1'b1, "edge3 coarse");
        check("R7", q_fine, 1'b1, "edge3 fine");
        #1;

        cur_req = "R1"; cycles(24);                 // divide by 2 and 4
        cur_req = "R8"; asel = 1; cycles(1);        // mid-period change waits for wrap
        cur_req = "R1"; cycles(36);                 // divide by 2 and 6
        cur_req = "R2"; fsel = 1; asel = 0; cycles(20);  // pass-through and 2
        asel = 1; cycles(30);                        // pass-through and 3

        // R3/R4: hold in pass-through ratio
        cur_req = "R3";
        run_n = 1; cycles(2);
        held = q_coarse;
        repeat (6) begin
            @(posedge clk); #3;
            check("R3", q_fine, 1'b0, "hold fine low");
            check("R3", q_coarse, held, "hold coarse stable");
        end
        #1;
        cur_req = "R4"; run_n = 0; cycles(9);
        run_n = 1; cycles(3); run_n = 0; cycles(10);

        // R8: select toggles inside a period, slow pair
        cur_req = "R8";
        fsel = 0; asel = 1; cycles(2);
        asel = 0; cycles(1); asel = 1; cycles(2); fsel = 1; cycles(1); fsel = 0;
        cycles(25);
        cur_req = "R5"; asel = 0; cycles(16);

        // R6/R7: reset in mid-run, release with gate closed, then open
        cur_req = "R6"; rst = 1; cycles(4);
        check("R6", q_coarse, 1'b0, "mid-run reset");
        cur_req = "R7"; run_n = 1; rst = 0; cycles(5);
        check("R7", q_coarse, 1'b0, "gate closed after release");
        run_n = 0; fsel = 1; asel = 1; cycles(20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule